// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block chooses the two operand values, A and B, for the instruction sitting in the decode stage of a five-stage in-order pipeline. Each operand is normally the value read from the register file. When an older instruction further down the pipe (in execute, memory or write-back) will write the register the decode instruction reads, the block takes the newer value straight from that stage's pipeline register or result bus. This way a dependent instruction can use an ALU result without waiting for it to be written back.

The selection is purely combinational, so the chosen values are ready within the same cycle that the decode stage is occupied. There are five bypass candidates, checked in a fixed order in which the most recently produced value wins. Operand A has one extra rule. For call and jump instructions it carries the incremented program counter, and that rule overrides all bypassing. Register ID 8 is reserved to mean "no register" and never counts as a match. The block has no clock, no state and no handshake. The stall logic that handles load-use cases sits elsewhere and is out of scope here.

Top module: `fwd_decode_bypass`

## Requirements
- R1: When `d_icode` equals the call code 4'h8, `op_a` equals `d_inc_pc` whatever the IDs and bypass values are.
- R2: When `d_icode` equals the jump code 4'h7, `op_a` equals `d_inc_pc` whatever the IDs and bypass values are.
- R3: Otherwise, if a source ID (not 8) equals `ex_dst`, the operand equals `ex_result`. This source has the highest priority.
- R4: Otherwise, if the source ID equals `mem_dst_ld`, the operand equals `mem_rdata`.
- R5: Otherwise, if the source ID equals `mem_dst_alu`, the operand equals `mem_result`.
- R6: Otherwise, if the source ID equals `wb_dst_ld`, the operand equals `wb_rdata`.
- R7: Otherwise, if the source ID equals `wb_dst_alu`, the operand equals `wb_result`.
- R8: If no destination ID matches, `op_a` equals `rf_rd_a` and `op_b` equals `rf_rd_b`.
- R9: A source ID of 8 never matches, even when one or more destination IDs are also 8. The register-file value then passes through.
- R10: `op_b` uses the same priority order (R3 to R8) against `d_src_b` and ignores the instruction code. A call or jump in decode does not place `d_inc_pc` on `op_b`.
- R11: Outputs change in the same evaluation as their inputs, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_icode | input | 4 | Instruction code of the decode-stage instruction |
| d_inc_pc | input | 32 | Incremented program counter of the decode instruction |
| d_src_a | input | 4 | Source register ID for operand A (8 = none) |
| d_src_b | input | 4 | Source register ID for operand B (8 = none) |
| ex_result | input | 32 | ALU result being produced in execute |
| ex_dst | input | 4 | Execute ALU-result destination ID |
| mem_rdata | input | 32 | Value loaded in the memory stage |
| mem_dst_ld | input | 4 | Memory-stage load destination ID |
| mem_result | input | 32 | ALU result held in the memory stage |
| mem_dst_alu | input | 4 | Memory-stage ALU-result destination ID |
| wb_rdata | input | 32 | Loaded value held in write-back |
| wb_dst_ld | input | 4 | Write-back load destination ID |
| wb_result | input | 32 | ALU result held in write-back |
| wb_dst_alu | input | 4 | Write-back ALU-result destination ID |
| rf_rd_a | input | 32 | Register-file read value for operand A |
| rf_rd_b | input | 32 | Register-file read value for operand B |
| op_a | output | 32 | Selected operand A |
| op_b | output | 32 | Selected operand B |

## Verification
The hardest situation to reach is several stages targeting the same register at once, where only the youngest writer may win. Three cases need care: a load and an ALU result in the memory stage aimed at one register, the "no register" ID appearing on both sides of a comparison, and a call or jump whose A source also matches a bypass. The stimulus sweeps every subset of the five destinations that match the source, for every source ID including 8, under several instruction codes. Every bypass value is distinct, so a wrong choice of winner always shows up as a wrong output.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned DATA_W_DFLT = 32;
  localparam int unsigned ID_W_DFLT   = 4;
  localparam int unsigned IC_W_DFLT   = 4;
  localparam int unsigned N_BYP       = 5;
  localparam logic [3:0]  NO_REG_DFLT = 4'd8;
  localparam logic [3:0]  CALL_DFLT   = 4'h8;
  localparam logic [3:0]  JUMP_DFLT   = 4'h7;

  // Bypass slot order: index 0 is the youngest producer and has top priority.
  typedef enum int unsigned {
    SLOT_EX_ALU  = 0,
    SLOT_MEM_LD  = 1,
    SLOT_MEM_ALU = 2,
    SLOT_WB_LD   = 3,
    SLOT_WB_ALU  = 4
  } byp_slot_e;
endpackage

// File: rtl/fwd_id_match.sv
module fwd_id_match #(
  parameter int unsigned ID_W      = 4,
  parameter int unsigned N         = 5,
  parameter logic [ID_W-1:0] NO_REG_ID = 8
) (
  input  logic [ID_W-1:0]         src_id,
  input  logic [N-1:0][ID_W-1:0]  dst_ids,
  output logic [N-1:0]            hit
);
  logic src_valid;
  assign src_valid = (src_id != NO_REG_ID);

  // A dst of NO_REG can only equal src when src is NO_REG, which is masked.
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = src_valid && (dst_ids[i] == src_id);
  end
endmodule

// File: rtl/fwd_prio_sel.sv
module fwd_prio_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N      = 5
) (
  input  logic [N-1:0]              hit,
  input  logic [N-1:0][DATA_W-1:0]  cand,
  input  logic [DATA_W-1:0]         fallback,
  output logic [DATA_W-1:0]         sel
);
  // Walk from the oldest slot to the youngest so the lowest index wins.
  always_comb begin
    sel = fallback;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) sel = cand[i];
    end
  end
endmodule

// File: rtl/fwd_operand.sv
module fwd_operand #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned N      = 5,
  parameter logic [ID_W-1:0] NO_REG_ID = 8
) (
  input  logic [ID_W-1:0]           src_id,
  input  logic [N-1:0][ID_W-1:0]    dst_ids,
  input  logic [N-1:0][DATA_W-1:0]  cand,
  input  logic [DATA_W-1:0]         rf_val,
  output logic [DATA_W-1:0]         value
);
  logic [N-1:0] hit;

  fwd_id_match #(
    .ID_W(ID_W), .N(N), .NO_REG_ID(NO_REG_ID)
  ) u_match (
    .src_id(src_id), .dst_ids(dst_ids), .hit(hit)
  );

  fwd_prio_sel #(
    .DATA_W(DATA_W), .N(N)
  ) u_sel (
    .hit(hit), .cand(cand), .fallback(rf_val), .sel(value)
  );
endmodule

// File: rtl/fwd_decode_bypass.sv
module fwd_decode_bypass
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DFLT,
  parameter int unsigned ID_W   = ID_W_DFLT,
  parameter int unsigned IC_W   = IC_W_DFLT,
  parameter logic [ID_W-1:0] NO_REG_ID = ID_W'(NO_REG_DFLT),
  parameter logic [IC_W-1:0] CALL_CODE = IC_W'(CALL_DFLT),
  parameter logic [IC_W-1:0] JUMP_CODE = IC_W'(JUMP_DFLT)
) (
  input  logic [IC_W-1:0]   d_icode,
  input  logic [DATA_W-1:0] d_inc_pc,
  input  logic [ID_W-1:0]   d_src_a,
  input  logic [ID_W-1:0]   d_src_b,
  input  logic [DATA_W-1:0] ex_result,
  input  logic [ID_W-1:0]   ex_dst,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [ID_W-1:0]   mem_dst_ld,
  input  logic [DATA_W-1:0] mem_result,
  input  logic [ID_W-1:0]   mem_dst_alu,
  input  logic [DATA_W-1:0] wb_rdata,
  input  logic [ID_W-1:0]   wb_dst_ld,
  input  logic [DATA_W-1:0] wb_result,
  input  logic [ID_W-1:0]   wb_dst_alu,
  input  logic [DATA_W-1:0] rf_rd_a,
  input  logic [DATA_W-1:0] rf_rd_b,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  localparam int unsigned N = N_BYP;

  logic [N-1:0][ID_W-1:0]   dsts;
  logic [N-1:0][DATA_W-1:0] cands;
  logic [DATA_W-1:0]        chain_a;
  logic                     take_pc;

  always_comb begin
    dsts[SLOT_EX_ALU]   = ex_dst;
    dsts[SLOT_MEM_LD]   = mem_dst_ld;
    dsts[SLOT_MEM_ALU]  = mem_dst_alu;
    dsts[SLOT_WB_LD]    = wb_dst_ld;
    dsts[SLOT_WB_ALU]   = wb_dst_alu;
    cands[SLOT_EX_ALU]  = ex_result;
    cands[SLOT_MEM_LD]  = mem_rdata;
    cands[SLOT_MEM_ALU] = mem_result;
    cands[SLOT_WB_LD]   = wb_rdata;
    cands[SLOT_WB_ALU]  = wb_result;
  end

  fwd_operand #(
    .DATA_W(DATA_W), .ID_W(ID_W), .N(N), .NO_REG_ID(NO_REG_ID)
  ) u_opa (
    .src_id(d_src_a), .dst_ids(dsts), .cand(cands),
    .rf_val(rf_rd_a), .value(chain_a)
  );

  fwd_operand #(
    .DATA_W(DATA_W), .ID_W(ID_W), .N(N), .NO_REG_ID(NO_REG_ID)
  ) u_opb (
    .src_id(d_src_b), .dst_ids(dsts), .cand(cands),
    .rf_val(rf_rd_b), .value(op_b)
  );

  // Control-transfer instructions carry the return/fall-through PC on A.
  assign take_pc = (d_icode == CALL_CODE) || (d_icode == JUMP_CODE);
  assign op_a    = take_pc ? d_inc_pc : chain_a;
endmodule

// File: rtl/fwd_decode_bypass_chk.sv
module fwd_decode_bypass_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned IC_W   = 4,
  parameter logic [ID_W-1:0] NO_REG_ID = 8,
  parameter logic [IC_W-1:0] CALL_CODE = 8,
  parameter logic [IC_W-1:0] JUMP_CODE = 7
) (
  input logic [IC_W-1:0]   d_icode,
  input logic [DATA_W-1:0] d_inc_pc,
  input logic [ID_W-1:0]   d_src_a,
  input logic [ID_W-1:0]   d_src_b,
  input logic [DATA_W-1:0] ex_result,
  input logic [ID_W-1:0]   ex_dst,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [ID_W-1:0]   mem_dst_ld,
  input logic [DATA_W-1:0] mem_result,
  input logic [ID_W-1:0]   mem_dst_alu,
  input logic [DATA_W-1:0] wb_rdata,
  input logic [ID_W-1:0]   wb_dst_ld,
  input logic [DATA_W-1:0] wb_result,
  input logic [ID_W-1:0]   wb_dst_alu,
  input logic [DATA_W-1:0] rf_rd_a,
  input logic [DATA_W-1:0] rf_rd_b,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b
);
  logic ctl_a, va, vb;
  assign va = (d_src_a != NO_REG_ID);
  assign vb = (d_src_b != NO_REG_ID);

  always_comb begin
    ctl_a = (d_icode == CALL_CODE) || (d_icode == JUMP_CODE);
    assert_call_pc_R1: assert (!(d_icode == CALL_CODE) || op_a == d_inc_pc);
    assert_jump_pc_R2: assert (!(d_icode == JUMP_CODE) || op_a == d_inc_pc);
    assert_ex_first_R3: assert (!(!ctl_a && va && d_src_a == ex_dst) || op_a == ex_result);
    assert_mem_ld_R4: assert (!(!ctl_a && va && d_src_a != ex_dst && d_src_a == mem_dst_ld)
                              || op_a == mem_rdata);
    assert_mem_alu_R5: assert (!(!ctl_a && va && d_src_a != ex_dst && d_src_a != mem_dst_ld
                                 && d_src_a == mem_dst_alu) || op_a == mem_result);
    assert_wb_ld_R6: assert (!(!ctl_a && va && d_src_a != ex_dst && d_src_a != mem_dst_ld
                               && d_src_a != mem_dst_alu && d_src_a == wb_dst_ld)
                             || op_a == wb_rdata);
    assert_rf_pass_R8: assert (!(!ctl_a && d_src_a != ex_dst && d_src_a != mem_dst_ld
                                 && d_src_a != mem_dst_alu && d_src_a != wb_dst_ld
                                 && d_src_a != wb_dst_alu) || op_a == rf_rd_a);
    assert_noreg_R9: assert (!(!ctl_a && !va) || op_a == rf_rd_a);
    assert_b_noreg_R10: assert (vb || op_b == rf_rd_b);
    assert_b_ex_R10: assert (!(vb && d_src_b == ex_dst) || op_b == ex_result);
    assert_b_wb_alu_R7: assert (!(vb && d_src_b != ex_dst && d_src_b != mem_dst_ld
                                  && d_src_b != mem_dst_alu && d_src_b != wb_dst_ld
                                  && d_src_b == wb_dst_alu) || op_b == wb_result);
  end
endmodule

bind fwd_decode_bypass fwd_decode_bypass_chk #(
  .DATA_W(DATA_W), .ID_W(ID_W), .IC_W(IC_W),
  .NO_REG_ID(NO_REG_ID), .CALL_CODE(CALL_CODE), .JUMP_CODE(JUMP_CODE)
) u_chk (.*);

// File: tb/sim_fwd_decode_bypass.sv
module sim_fwd_decode_bypass;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [3:0]  d_icode, d_src_a, d_src_b;
  logic [31:0] d_inc_pc, ex_result, mem_rdata, mem_result, wb_rdata, wb_result;
  logic [3:0]  ex_dst, mem_dst_ld, mem_dst_alu, wb_dst_ld, wb_dst_alu;
  logic [31:0] rf_rd_a, rf_rd_b, op_a, op_b;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  fwd_decode_bypass u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Expected operand from the requirements; sets tag to the governing rule.
  function automatic logic [31:0] model(input logic [3:0] src, input bit use_pc,
                                        input logic [31:0] rf, output string tag);
    if (use_pc) begin tag = (d_icode == 4'h8) ? "R1" : "R2"; return d_inc_pc; end
    if (src == 4'd8) begin tag = "R9"; return rf; end
    if (src == ex_dst)      begin tag = "R3"; return ex_result; end
    if (src == mem_dst_ld)  begin tag = "R4"; return mem_rdata; end
    if (src == mem_dst_alu) begin tag = "R5"; return mem_result; end
    if (src == wb_dst_ld)   begin tag = "R6"; return wb_rdata; end
    if (src == wb_dst_alu)  begin tag = "R7"; return wb_result; end
    tag = "R8";
    return rf;
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [3:0] codes [4] = '{4'h0, 4'h7, 4'h8, 4'h2};
    string tag;
    logic [31:0] e;

    // Quiescent state: no sources, no destinations -> register-file values (R8).
    d_icode = 4'h0; d_src_a = 4'd8; d_src_b = 4'd8; d_inc_pc = 32'h0000_1234;
    ex_dst = 4'd8; mem_dst_ld = 4'd8; mem_dst_alu = 4'd8; wb_dst_ld = 4'd8; wb_dst_alu = 4'd8;
    ex_result = 32'h1; mem_rdata = 32'h2; mem_result = 32'h3; wb_rdata = 32'h4; wb_result = 32'h5;
    rf_rd_a = 32'hAAAA_0000; rf_rd_b = 32'hBBBB_0000;
    @(negedge clk); #1;
    chk("R8 idle A", op_a, 32'hAAAA_0000);
    chk("R8 idle B", op_b, 32'hBBBB_0000);

    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s <= 8; s++) begin
        for (int m = 0; m < 32; m++) begin
          logic [3:0] src, miss;
          src  = 4'(s);
          miss = (s == 8) ? 4'd2 : 4'd8;
          @(negedge clk);
          d_icode     = codes[c];
          d_src_a     = src;
          d_src_b     = src;
          d_inc_pc    = 32'hC000_0000 | (32'(c) << 12) | (32'(s) << 8) | 32'(m);
          ex_dst      = m[0] ? src : miss;
          mem_dst_ld  = m[1] ? src : miss;
          mem_dst_alu = m[2] ? src : miss;
          wb_dst_ld   = m[3] ? src : miss;
          wb_dst_alu  = m[4] ? src : miss;
          ex_result   = 32'h1000_0000 + 32'(m) * 16 + 32'(s);
          mem_rdata   = 32'h2000_0000 + 32'(m) * 16 + 32'(s);
          mem_result  = 32'h3000_0000 + 32'(m) * 16 + 32'(s);
          wb_rdata    = 32'h4000_0000 + 32'(m) * 16 + 32'(s);
          wb_result   = 32'h5000_0000 + 32'(m) * 16 + 32'(s);
          rf_rd_a     = 32'hA000_0000 + 32'(m) * 16 + 32'(s);
          rf_rd_b     = 32'hB000_0000 + 32'(m) * 16 + 32'(s);
          #1;  // R11: same evaluation, no clock edge in between
          e = model(src, (codes[c] == 4'h7) || (codes[c] == 4'h8), rf_rd_a, tag);
          chk({tag, " op_a"}, op_a, e);
          e = model(src, 1'b0, rf_rd_b, tag);
          chk({tag, " R10 op_b"}, op_b, e);
        end
      end
    end

    done = 1;
    summary();
  end
endmodule